// File: doc/BRIEF.md
# Pushbutton volume and mute controller

This block holds a 5-bit listening level (0 = silent, 31 = loudest) and a mute state for a stereo amplifier. Three active-low pushbuttons drive it: step up, step down and mute. Each button has to be held for a minimum time before it counts. Once released, it has to stay released for the same minimum time before it can be pressed again. Holding step up or step down past a long-hold limit makes the level repeat its step at a fixed rate. The mute button toggles the mute state and never repeats.

When reset is released, a two-pin strap selects the starting level. An active-low boost pin doubles the level that is driven to the gain path. An active-high shutdown input forces the gain output to zero and ignores all buttons while it is high, but it leaves the stored level and the mute state as they are. All timing is counted in strobes of a shared prescaler. The strobe rate comes from the system clock frequency parameter. The pulse, hold and repeat times are set in microseconds or milliseconds by parameters (defaults 200 µs, 1000 ms and 100 ms).

Each button runs its own state machine: BTN_IDLE, BTN_PRESS (qualifying), BTN_HOLD (qualified, waiting for the long hold), BTN_RPT (repeating) and BTN_GAP (release spacing).
- BTN_IDLE goes to BTN_PRESS on a press.
- BTN_PRESS returns to BTN_IDLE on an early release, or goes to BTN_HOLD and fires one step on its qualifying strobe.
- BTN_HOLD goes to BTN_GAP on release, or to BTN_RPT and fires when the hold count expires (step buttons only).
- BTN_RPT fires every repeat period and goes to BTN_GAP on release.
- BTN_GAP goes back to BTN_IDLE after the spacing count. A press during BTN_GAP restarts that count.

The level state machine has three states: LVL_LOAD, LVL_PLAY and LVL_MUTED.
- LVL_LOAD loads the strap value and moves to LVL_PLAY.
- LVL_PLAY applies steps and moves to LVL_MUTED on a mute fire.
- LVL_MUTED moves back to LVL_PLAY on a mute fire.

Top module: `vol_mute_ctrl`

## Requirements
- R1: The stored level `vol_level` is 5 bits wide and moves by exactly one per accepted step. It saturates at 31 on step up and at 0 on step down, with no wraparound.
- R2: On the first clock edge after `rst_n` rises, the level loads from `preset_sel`: 2'b00 gives 31, 2'b01 gives 16, 2'b10 gives 9, 2'b11 gives 0. Later changes of `preset_sel` have no effect until the next reset release.
- R3: While `rst_n` is low, `vol_level`, `gain_level` and `mute_led` are all 0. After release the block starts unmuted.
- R4: A press acts only after it has been held low for MIN_TICKS consecutive prescaler strobes (200 µs by default). The step takes effect on the clock edge of the qualifying strobe. A shorter press does nothing.
- R5: After a release, a button must stay high for MIN_TICKS strobes before a new press is accepted. A press inside that spacing is ignored and restarts the spacing count.
- R6: A step button held past qualification for HOLD_TICKS strobes (1 s by default) steps once more. It then steps every REPEAT_TICKS strobes (100 ms by default) until it is released.
- R7: Each qualified mute press toggles the mute state, however long it is held. `mute_led` is 1 while muted and 0 otherwise.
- R8: While muted, `gain_level` is 0 and step presses are ignored. Leaving mute restores `gain_level` from the unchanged stored level.
- R9: With `boost_n` high, `gain_level` equals `vol_level`. With `boost_n` low, `gain_level` is twice `vol_level` (`gain_level[5:1]` = `vol_level`, bit 0 = 0), at most 62.
- R10: While `shutdown` is high, `gain_level` is 0 and all button actions are ignored. The stored level and mute state are kept, and the preset is not reloaded when `shutdown` falls.
- R11: While step up and step down are both held low, neither button acts.
- R12: Every button, `boost_n` and `shutdown` pass through a two-flop synchroniser. A change on `shutdown` or `boost_n` reaches `gain_level` two clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the preset loads when it is released |
| vol_up_n | input | 1 | Step-up pushbutton, active low |
| vol_down_n | input | 1 | Step-down pushbutton, active low |
| mute_n | input | 1 | Mute toggle pushbutton, active low |
| boost_n | input | 1 | Level doubling enable, active low |
| shutdown | input | 1 | Emergency shutdown, active high |
| preset_sel | input | 2 | Starting level strap (00:31, 01:16, 10:9, 11:0) |
| vol_level | output | 5 | Stored level 0..31 |
| gain_level | output | 6 | Effective level to the gain path, 0..62 |
| mute_led | output | 1 | High while muted |

## Verification
The timing of every result can be predicted exactly. A pushbutton edge is seen two clocks after it is applied. A step or mute toggle then lands on the clock edge of the prescaler strobe that completes its count (the qualifying, hold or repeat count). `gain_level` follows `shutdown` or `boost_n` two edges after the input changes. The stored level loads on the first edge after reset release.

The bench keeps a behavioural model that moves through these delays in the same clock edges. It compares all three outputs a quarter period after every rising edge, so inputs (driven on falling edges) and outputs are never sampled while they switch. The directed checks wait long enough for the worst-case strobe phase, or, for auto-repeat, pick hold lengths whose step counts do not depend on that phase.

// File: rtl/vmc_pkg.sv
package vmc_pkg;

    localparam int VOL_W   = 5;
    localparam int GAIN_W  = VOL_W + 1;
    localparam int VOL_MAX = (1 << VOL_W) - 1;

    localparam int BTN_INC  = 0;
    localparam int BTN_DEC  = 1;
    localparam int BTN_MUTE = 2;
    localparam int NUM_BTN  = 3;

    // synchroniser lane order
    localparam int LANE_BOOST = 3;
    localparam int LANE_SHUT  = 4;
    localparam int NUM_LANES  = 5;

    typedef enum logic [2:0] {
        BTN_IDLE,
        BTN_PRESS,
        BTN_HOLD,
        BTN_RPT,
        BTN_GAP
    } btn_state_t;

    typedef enum logic [1:0] {
        LVL_LOAD,
        LVL_PLAY,
        LVL_MUTED
    } lvl_state_t;

    function automatic logic [VOL_W-1:0] preset_level(input logic [1:0] sel);
        logic [VOL_W-1:0] lvl;
        unique case (sel)
            2'b00:   lvl = VOL_W'(VOL_MAX);
            2'b01:   lvl = VOL_W'(16);
            2'b10:   lvl = VOL_W'(9);
            default: lvl = '0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/vmc_sync.sv
module vmc_sync #(
    parameter int                 WIDTH     = 1,
    parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RESET_VAL;
            sync_q <= RESET_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/vmc_tick.sv
module vmc_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

endmodule

// File: rtl/vmc_button.sv
module vmc_button
    import vmc_pkg::*;
#(
    parameter int MIN_TICKS    = 2,
    parameter int HOLD_TICKS   = 10,
    parameter int REPEAT_TICKS = 5,
    parameter bit REPEAT_EN    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic press_i,
    output logic fire_o
);

    localparam int MAXT_A = (MIN_TICKS > HOLD_TICKS) ? MIN_TICKS : HOLD_TICKS;
    localparam int MAXT   = (MAXT_A > REPEAT_TICKS) ? MAXT_A : REPEAT_TICKS;
    localparam int CW     = $clog2(MAXT + 1);
    localparam logic [CW-1:0] MIN_LAST  = CW'(MIN_TICKS - 1);
    localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);
    localparam logic [CW-1:0] REP_LAST  = CW'(REPEAT_TICKS - 1);

    btn_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BTN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BTN_IDLE: begin
                if (press_i) begin
                    state_d = BTN_PRESS;
                    cnt_d   = '0;
                end
            end
            BTN_PRESS: begin
                if (!press_i) begin
                    state_d = BTN_IDLE;
                end else if (tick_i) begin
                    if (cnt_q == MIN_LAST) begin
                        state_d = BTN_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            BTN_HOLD: begin
                if (!press_i) begin
                    state_d = BTN_GAP;
                    cnt_d   = '0;
                end else if (tick_i && REPEAT_EN) begin
                    if (cnt_q == HOLD_LAST) begin
                        state_d = BTN_RPT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            BTN_RPT: begin
                if (!press_i) begin
                    state_d = BTN_GAP;
                    cnt_d   = '0;
                end else if (tick_i) begin
                    if (cnt_q == REP_LAST) begin
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            BTN_GAP: begin
                if (press_i) begin
                    cnt_d = '0;
                end else if (tick_i) begin
                    if (cnt_q == MIN_LAST) begin
                        state_d = BTN_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = BTN_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        fire_o = 1'b0;
        if (press_i && tick_i) begin
            unique case (state_q)
                BTN_PRESS: fire_o = (cnt_q == MIN_LAST);
                BTN_HOLD:  fire_o = REPEAT_EN && (cnt_q == HOLD_LAST);
                BTN_RPT:   fire_o = (cnt_q == REP_LAST);
                default:   fire_o = 1'b0;
            endcase
        end
    end

    // a qualifying fire needs the press to have been seen on the cycle before too
    assert_qualify_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && state_q == BTN_PRESS) |-> $past(press_i));

endmodule

// File: rtl/vmc_level.sv
module vmc_level
    import vmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        preset_sel,
    input  logic              inc_fire_i,
    input  logic              dec_fire_i,
    input  logic              mute_fire_i,
    input  logic              shut_i,
    input  logic              boost_n_i,
    output logic [VOL_W-1:0]  vol_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic              mute_o
);

    localparam logic [VOL_W-1:0] VOL_TOP = VOL_W'(VOL_MAX);

    lvl_state_t       state_q, state_d;
    logic [VOL_W-1:0] vol_q, vol_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_LOAD;
            vol_q   <= '0;
        end else begin
            state_q <= state_d;
            vol_q   <= vol_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        vol_d   = vol_q;
        unique case (state_q)
            LVL_LOAD: begin
                vol_d   = preset_level(preset_sel);
                state_d = LVL_PLAY;
            end
            LVL_PLAY: begin
                if (!shut_i) begin
                    if (mute_fire_i) begin
                        state_d = LVL_MUTED;
                    end else if (inc_fire_i && vol_q != VOL_TOP) begin
                        vol_d = vol_q + 1'b1;
                    end else if (dec_fire_i && vol_q != '0) begin
                        vol_d = vol_q - 1'b1;
                    end
                end
            end
            LVL_MUTED: begin
                if (!shut_i && mute_fire_i) begin
                    state_d = LVL_PLAY;
                end
            end
            default: state_d = LVL_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        vol_o  = vol_q;
        mute_o = (state_q == LVL_MUTED);
        if (state_q != LVL_PLAY || shut_i) begin
            gain_o = '0;
        end else if (!boost_n_i) begin
            gain_o = {vol_q, 1'b0};
        end else begin
            gain_o = {1'b0, vol_q};
        end
    end

    assert_preset_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LVL_LOAD) |=> (vol_q == preset_level($past(preset_sel))));

    assert_mute_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LVL_MUTED) |=> $stable(vol_q));

    assert_shut_freezes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_i && state_q != LVL_LOAD) |=> ($stable(vol_q) && $stable(state_q)));

    assert_step_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LVL_LOAD) |=>
            ({1'b0, vol_q} == {1'b0, $past(vol_q)} ||
             {1'b0, vol_q} == {1'b0, $past(vol_q)} + 6'd1 ||
             {1'b0, vol_q} + 6'd1 == {1'b0, $past(vol_q)}));

endmodule

// File: rtl/vol_mute_ctrl.sv
module vol_mute_ctrl
    import vmc_pkg::*;
#(
    parameter int CLK_HZ       = 12_288_000,
    parameter int TICK_HZ      = 10_000,
    parameter int MIN_PULSE_US = 200,
    parameter int HOLD_MS      = 1000,
    parameter int REPEAT_MS    = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vol_up_n,
    input  logic        vol_down_n,
    input  logic        mute_n,
    input  logic        boost_n,
    input  logic        shutdown,
    input  logic [1:0]  preset_sel,
    output logic [4:0]  vol_level,
    output logic [5:0]  gain_level,
    output logic        mute_led
);

    localparam int DIV_RAW    = CLK_HZ / TICK_HZ;
    localparam int TICK_DIV   = (DIV_RAW > 0) ? DIV_RAW : 1;
    localparam int MIN_RAW    = (TICK_HZ * MIN_PULSE_US) / 1_000_000;
    localparam int MIN_TICKS  = (MIN_RAW > 0) ? MIN_RAW : 1;
    localparam int HOLD_RAW   = (TICK_HZ / 1000) * HOLD_MS;
    localparam int HOLD_TICKS = (HOLD_RAW > 0) ? HOLD_RAW : 1;
    localparam int REP_RAW    = (TICK_HZ / 1000) * REPEAT_MS;
    localparam int REP_TICKS  = (REP_RAW > 0) ? REP_RAW : 1;
    localparam logic [NUM_LANES-1:0] SYNC_IDLE = NUM_LANES'(5'b01111);

    logic [NUM_LANES-1:0] raw_in, sync_in;
    logic [NUM_BTN-1:0]   press, fire;
    logic                 tick;

    assign raw_in = {shutdown, boost_n, mute_n, vol_down_n, vol_up_n};

    vmc_sync #(.WIDTH(NUM_LANES), .RESET_VAL(SYNC_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    vmc_tick #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    // a step button counts as pressed only while the opposite one is released
    assign press[BTN_INC]  = !sync_in[BTN_INC] &&  sync_in[BTN_DEC];
    assign press[BTN_DEC]  = !sync_in[BTN_DEC] &&  sync_in[BTN_INC];
    assign press[BTN_MUTE] = !sync_in[BTN_MUTE];

    for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
        vmc_button #(
            .MIN_TICKS    (MIN_TICKS),
            .HOLD_TICKS   (HOLD_TICKS),
            .REPEAT_TICKS (REP_TICKS),
            .REPEAT_EN    (g != BTN_MUTE)
        ) u_btn (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .press_i (press[g]),
            .fire_o  (fire[g])
        );
    end

    vmc_level u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .preset_sel  (preset_sel),
        .inc_fire_i  (fire[BTN_INC]),
        .dec_fire_i  (fire[BTN_DEC]),
        .mute_fire_i (fire[BTN_MUTE]),
        .shut_i      (sync_in[LANE_SHUT]),
        .boost_n_i   (sync_in[LANE_BOOST]),
        .vol_o       (vol_level),
        .gain_o      (gain_level),
        .mute_o      (mute_led)
    );

    assert_no_both_steps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fire[BTN_INC], fire[BTN_DEC]}));

    assert_mute_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mute_led |-> (gain_level == 6'd0));

endmodule

// File: tb/vol_mute_ctrl_test.sv
module vol_mute_ctrl_test;

    localparam int CLK_PERIOD  = 10;
    localparam int TB_CLK_HZ   = 40_000;
    localparam int TB_TICK_HZ  = 10_000;
    localparam int TB_MIN_US   = 200;
    localparam int TB_HOLD_MS  = 20;
    localparam int TB_REP_MS   = 5;
    localparam int TB_DIV      = TB_CLK_HZ / TB_TICK_HZ;
    localparam int TB_MIN      = (TB_TICK_HZ * TB_MIN_US) / 1_000_000;
    localparam int TB_HOLD     = (TB_TICK_HZ / 1000) * TB_HOLD_MS;
    localparam int TB_REP      = (TB_TICK_HZ / 1000) * TB_REP_MS;
    localparam int WATCHDOG    = 200_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_n = 1'b1, dn_n = 1'b1, mu_n = 1'b1, bo_n = 1'b1, sd = 1'b0;
    logic [1:0] sel = 2'b01;
    logic [4:0] vol_level;
    logic [5:0] gain_level;
    logic       mute_led;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R3";

    always #(CLK_PERIOD / 2) clk = ~clk;

    vol_mute_ctrl #(
        .CLK_HZ(TB_CLK_HZ), .TICK_HZ(TB_TICK_HZ), .MIN_PULSE_US(TB_MIN_US),
        .HOLD_MS(TB_HOLD_MS), .REPEAT_MS(TB_REP_MS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .vol_up_n(up_n), .vol_down_n(dn_n),
        .mute_n(mu_n), .boost_n(bo_n), .shutdown(sd), .preset_sel(sel),
        .vol_level(vol_level), .gain_level(gain_level), .mute_led(mute_led)
    );

    // ---------------- behavioural reference model ----------------
    int m_s1[5], m_s2[5], m_raw[5];
    int m_ph[3], m_cnt[3], m_fire[3], m_pr[3];
    int m_pcnt, m_lst, m_vol, m_gain, m_led, m_tk;
    bit m_valid = 1'b0;

    function automatic int preset_of(input logic [1:0] s);
        case (s)
            2'b00:   return 31;
            2'b01:   return 16;
            2'b10:   return 9;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        m_raw[0] = up_n; m_raw[1] = dn_n; m_raw[2] = mu_n; m_raw[3] = bo_n; m_raw[4] = sd;
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin
                m_s1[i] = (i == 4) ? 0 : 1;
                m_s2[i] = m_s1[i];
            end
            for (int b = 0; b < 3; b++) begin m_ph[b] = 0; m_cnt[b] = 0; end
            m_pcnt = 0; m_lst = 0; m_vol = 0;
        end else begin
            m_tk = (m_pcnt == TB_DIV - 1);
            m_pr[0] = (m_s2[0] == 0 && m_s2[1] == 1);
            m_pr[1] = (m_s2[1] == 0 && m_s2[0] == 1);
            m_pr[2] = (m_s2[2] == 0);
            for (int b = 0; b < 3; b++) begin
                m_fire[b] = 0;
                case (m_ph[b])
                    0: if (m_pr[b]) begin m_ph[b] = 1; m_cnt[b] = 0; end
                    1: if (!m_pr[b]) m_ph[b] = 0;
                       else if (m_tk) begin
                           m_cnt[b]++;
                           if (m_cnt[b] == TB_MIN) begin m_fire[b] = 1; m_ph[b] = 2; m_cnt[b] = 0; end
                       end
                    2: if (!m_pr[b]) begin m_ph[b] = 4; m_cnt[b] = 0; end
                       else if (m_tk && b != 2) begin
                           m_cnt[b]++;
                           if (m_cnt[b] == TB_HOLD) begin m_fire[b] = 1; m_ph[b] = 3; m_cnt[b] = 0; end
                       end
                    3: if (!m_pr[b]) begin m_ph[b] = 4; m_cnt[b] = 0; end
                       else if (m_tk) begin
                           m_cnt[b]++;
                           if (m_cnt[b] == TB_REP) begin m_fire[b] = 1; m_cnt[b] = 0; end
                       end
                    default: if (m_pr[b]) m_cnt[b] = 0;
                       else if (m_tk) begin
                           m_cnt[b]++;
                           if (m_cnt[b] == TB_MIN) begin m_ph[b] = 0; m_cnt[b] = 0; end
                       end
                endcase
            end
            if (m_lst == 0) begin
                m_vol = preset_of(sel);
                m_lst = 1;
            end else if (m_s2[4] == 0) begin
                if (m_lst == 1) begin
                    if (m_fire[2] != 0) m_lst = 2;
                    else if (m_fire[0] != 0 && m_vol < 31) m_vol++;
                    else if (m_fire[1] != 0 && m_vol > 0) m_vol--;
                end else if (m_fire[2] != 0) begin
                    m_lst = 1;
                end
            end
            for (int i = 0; i < 5; i++) begin m_s2[i] = m_s1[i]; m_s1[i] = m_raw[i]; end
            m_pcnt = (m_pcnt == TB_DIV - 1) ? 0 : m_pcnt + 1;
        end
        m_led  = (m_lst == 2);
        m_gain = (m_lst != 1 || m_s2[4] != 0) ? 0 : ((m_s2[3] == 0) ? 2 * m_vol : m_vol);
        m_valid = 1'b1;
    end

    // compare every clock, a quarter period after the rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD / 4);
        if (m_valid && !done) begin
            n_vec++;
            if (int'(vol_level) != m_vol || int'(gain_level) != m_gain || int'(mute_led) != m_led) begin
                n_bad++;
                $display("FAIL %s model compare: vol %0d exp %0d, gain %0d exp %0d, led %0d exp %0d",
                         cur_req, vol_level, m_vol, gain_level, m_gain, mute_led, m_led);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_btn(input int idx, input logic v);
        case (idx)
            0: up_n = v;
            1: dn_n = v;
            default: mu_n = v;
        endcase
    endtask

    task automatic press(input int idx, input int n);
        @(negedge clk);
        set_btn(idx, 1'b0);
        clocks(n);
        set_btn(idx, 1'b1);
        clocks(16);
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        sel = s;
        clocks(3);
        rst_n = 1'b1;
        clocks(4);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        // R3 reset state
        cur_req = "R3";
        clocks(3);
        chk("R3 vol in reset", vol_level, 0);
        chk("R3 gain in reset", gain_level, 0);
        chk("R3 led in reset", mute_led, 0);
        @(negedge clk); rst_n = 1'b1;
        clocks(4);
        cur_req = "R2";
        chk("R2 preset 01", vol_level, 16);
        chk("R3 unmuted after release", mute_led, 0);
        sel = 2'b11;
        clocks(10);
        chk("R2 strap ignored after release", vol_level, 16);

        // R4 short press ignored, long press steps once
        cur_req = "R4";
        press(0, 4);
        chk("R4 short press ignored", vol_level, 16);
        press(0, 12);
        chk("R4 qualified step up", vol_level, 17);

        // R5 press inside release spacing ignored
        cur_req = "R5";
        @(negedge clk); up_n = 1'b0;
        clocks(12); up_n = 1'b1;
        clocks(2);  up_n = 1'b0;
        clocks(12); up_n = 1'b1;
        clocks(16);
        chk("R5 second press within gap ignored", vol_level, 18);
        cur_req = "R4";
        press(1, 12);
        chk("R4 qualified step down", vol_level, 17);

        // R9 boost
        cur_req = "R9";
        @(negedge clk); bo_n = 1'b0;
        clocks(4);
        chk("R9 boosted gain", gain_level, 34);
        @(negedge clk); bo_n = 1'b1;
        clocks(4);
        chk("R9 normal gain", gain_level, 17);

        // R12 synchroniser latency on shutdown
        cur_req = "R12";
        @(negedge clk); sd = 1'b1;
        @(negedge clk);
        chk("R12 gain after one edge", gain_level, 17);
        @(negedge clk);
        chk("R12 gain after two edges", gain_level, 0);

        // R10 shutdown keeps state, ignores buttons
        cur_req = "R10";
        press(0, 12);
        chk("R10 step ignored in shutdown", vol_level, 17);
        press(2, 12);
        chk("R10 mute ignored in shutdown", mute_led, 0);
        @(negedge clk); sd = 1'b0;
        clocks(4);
        chk("R10 level kept, no preset reload", vol_level, 17);
        chk("R10 gain back", gain_level, 17);

        // R7 mute toggles once even if held, R8 restore
        cur_req = "R7";
        press(2, 1200);
        chk("R7 long mute press toggles once", mute_led, 1);
        cur_req = "R8";
        chk("R8 gain zero while muted", gain_level, 0);
        press(0, 12);
        chk("R8 step ignored while muted", vol_level, 17);
        cur_req = "R7";
        press(2, 12);
        chk("R7 second toggle unmutes", mute_led, 0);
        cur_req = "R8";
        chk("R8 gain restored", gain_level, 17);

        // R11 both step buttons low
        cur_req = "R11";
        @(negedge clk); up_n = 1'b0; dn_n = 1'b0;
        clocks(1200);
        up_n = 1'b1; dn_n = 1'b1;
        clocks(16);
        chk("R11 both held, no change", vol_level, 17);

        // R6 auto-repeat: qualify + hold + two repeats
        cur_req = "R6";
        press(0, 1400);
        chk("R6 auto-repeat step count", vol_level, 21);

        // R1 saturation at top and boost max
        cur_req = "R1";
        press(0, 3000);
        chk("R1 saturate at 31", vol_level, 31);
        cur_req = "R9";
        @(negedge clk); bo_n = 1'b0;
        clocks(4);
        chk("R9 boost max 62", gain_level, 62);
        @(negedge clk); bo_n = 1'b1;
        clocks(4);
        cur_req = "R1";
        press(1, 8000);
        chk("R1 saturate at 0", vol_level, 0);
        press(0, 12);
        chk("R1 step from 0", vol_level, 1);

        // R2 other presets, R3 reset clears mute
        cur_req = "R3";
        press(2, 12);
        chk("R7 muted before reset", mute_led, 1);
        @(negedge clk); rst_n = 1'b0; sel = 2'b10;
        clocks(2);
        chk("R3 reset clears led", mute_led, 0);
        chk("R3 reset clears vol", vol_level, 0);
        @(negedge clk); rst_n = 1'b1;
        clocks(4);
        cur_req = "R2";
        chk("R2 preset 10", vol_level, 9);
        do_reset(2'b00);
        chk("R2 preset 00", vol_level, 31);
        do_reset(2'b11);
        chk("R2 preset 11", vol_level, 0);
        chk("R2 preset 11 gain", gain_level, 0);

        clocks(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule